// File: doc/BRIEF.md
# Per-Pin Edge Event Generator

This block watches a vector of general-purpose pin levels and emits a one-clock event pulse for each pin on the edges that software has selected. Each pin carries two enable bits from the register bank, one for rising and one for falling transitions. Together they give four modes: off, rising only, falling only, or both edges. A single bank-wide enable bit gates every pin at once. One event output per pin feeds both the CPU interrupt controller and the DMA request logic.

Pin levels may change at any time relative to the peripheral clock, so each pin first passes through a synchronizer chain. Edges are then found by comparing the synchronized level with one further registered copy. Detection looks only at the pin level, so a pin driven as an output produces events when software toggles its output-data bit and the level loops back.

An edge that is seen while the bank enable is low is lost; it is never held pending. After reset, a short warm-up window masks the output while the synchronizer fills with real pin levels.

Top module: `pin_edge_event`

## Requirements
- R1: While `rst` is high, and for the first 3 clock edges after `rst` falls (SYNC_STAGES+1 with the default of 2), `evt_pulse` is all zeros, even when pins are held high.
- R2: A pin with `rise_en`=1 and `fall_en`=0 pulses on a low-to-high level change only. A high-to-low change gives no pulse.
- R3: A pin with `rise_en`=0 and `fall_en`=1 pulses on a high-to-low level change only. A low-to-high change gives no pulse.
- R4: A pin with both enables at 1 pulses on every level change in either direction.
- R5: A pin with both enables at 0 never pulses, whatever its level does.
- R6: A pin level change set up before clock edge k shows as a pulse in the cycle after edge k+2 (three edges of latency). For an isolated change the pulse is exactly one cycle wide.
- R7: While `bank_en` is 0, `evt_pulse` stays 0. An edge detected in that time is dropped and does not appear after `bank_en` returns to 1.
- R8: Pins are independent. Each pin's pulse depends only on its own level and its own two enable bits.
- R9: A change to `rise_en` or `fall_en` while the pin level holds steady produces no pulse. A new enable value applies to the edge evaluated at the next clock.
- R10: A pin toggling on every clock in both-edge mode produces a pulse on every cycle, with no change merged or lost.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_level | input | PIN_COUNT | Raw pin levels, possibly asynchronous |
| rise_en | input | PIN_COUNT | Per-pin rising-edge enable |
| fall_en | input | PIN_COUNT | Per-pin falling-edge enable |
| bank_en | input | 1 | Bank-wide event enable |
| evt_pulse | output | PIN_COUNT | Per-pin one-clock event pulse |

## Verification
The assertions assume that the enable inputs are stable around each clock edge and that `bank_en`, `rise_en` and `fall_en` come from registers in the same clock domain. Only `pin_level` is allowed to be asynchronous. The stimulus changes every input at the falling clock edge, so all enables meet this assumption. Pin changes come both from the random generator and from directed patterns: isolated steps, every-cycle toggling, and levels held through reset.

// File: rtl/pes_pkg.sv
package pes_pkg;

    // Minimum depth of the metastability chain.
    localparam int MIN_SYNC_STAGES = 2;

    // Per-pin mode; encoding is {rise_enable, fall_enable}.
    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_FALL = 2'b01,
        EDGE_RISE = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_mode_e;

    // Synchronized level and its one-cycle-older copy.
    typedef struct packed {
        logic cur;
        logic prev;
    } lvl_pair_t;

    function automatic edge_mode_e mode_of(input logic rise, input logic fall);
        edge_mode_e m;
        unique case ({rise, fall})
            2'b00:   m = EDGE_OFF;
            2'b01:   m = EDGE_FALL;
            2'b10:   m = EDGE_RISE;
            default: m = EDGE_BOTH;
        endcase
        return m;
    endfunction

    function automatic logic is_rise(input lvl_pair_t l);
        return l.cur & ~l.prev;
    endfunction

    function automatic logic is_fall(input lvl_pair_t l);
        return ~l.cur & l.prev;
    endfunction

    // True when the level pair holds an edge that the mode selects.
    function automatic logic edge_hit(input edge_mode_e m, input lvl_pair_t l);
        logic hit;
        unique case (m)
            EDGE_OFF:  hit = 1'b0;
            EDGE_FALL: hit = is_fall(l);
            EDGE_RISE: hit = is_rise(l);
            default:   hit = is_rise(l) | is_fall(l);
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/pes_sync.sv
module pes_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    import pes_pkg::*;

    localparam int DEPTH = (STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : STAGES;

    logic [DEPTH-1:0][WIDTH-1:0] chain_q;

    generate
        for (genvar s = 0; s < DEPTH; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= '0;
                    else     chain_q[s] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) chain_q[s] <= '0;
                    else     chain_q[s] <= chain_q[s-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain_q[DEPTH-1];

endmodule

// File: rtl/pes_warmup.sv
module pes_warmup #(
    parameter int HOLD = 3
) (
    input  logic clk,
    input  logic rst,
    output logic ready
);
    localparam int CW = $clog2(HOLD + 1);
    localparam logic [CW-1:0] LIMIT = CW'(HOLD);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (cnt_q < LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    assign ready = (cnt_q == LIMIT);

endmodule

// File: rtl/pes_edge_detect.sv
module pes_edge_detect #(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] sync_lvl,
    input  logic [WIDTH-1:0] rise_en,
    input  logic [WIDTH-1:0] fall_en,
    input  logic             fire_ok,
    output logic [WIDTH-1:0] hist_lvl,
    output logic [WIDTH-1:0] evt
);
    import pes_pkg::*;

    generate
        for (genvar i = 0; i < WIDTH; i++) begin : g_pin
            lvl_pair_t  pair;
            edge_mode_e mode;
            logic       hist_q;
            logic       evt_q;

            assign pair.cur  = sync_lvl[i];
            assign pair.prev = hist_q;
            assign mode      = mode_of(rise_en[i], fall_en[i]);

            // History always tracks the level so that no stale edge survives.
            always_ff @(posedge clk) begin
                if (rst) hist_q <= 1'b0;
                else     hist_q <= sync_lvl[i];
            end

            // Qualified edge registered into a one-cycle pulse; a blocked edge is lost.
            always_ff @(posedge clk) begin
                if (rst) evt_q <= 1'b0;
                else     evt_q <= fire_ok & edge_hit(mode, pair);
            end

            assign hist_lvl[i] = hist_q;
            assign evt[i]      = evt_q;
        end
    endgenerate

endmodule

// File: rtl/pin_edge_event.sv
module pin_edge_event #(
    parameter int PIN_COUNT   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [PIN_COUNT-1:0] pin_level,
    input  logic [PIN_COUNT-1:0] rise_en,
    input  logic [PIN_COUNT-1:0] fall_en,
    input  logic                 bank_en,
    output logic [PIN_COUNT-1:0] evt_pulse
);
    import pes_pkg::*;

    localparam int DEPTH = (SYNC_STAGES < MIN_SYNC_STAGES) ? MIN_SYNC_STAGES : SYNC_STAGES;
    localparam int WARM  = DEPTH + 1;

    logic [PIN_COUNT-1:0] sync_lvl;
    logic [PIN_COUNT-1:0] hist_lvl;
    logic                 warm_ready;
    logic                 fire_ok;

    pes_sync #(
        .WIDTH  (PIN_COUNT),
        .STAGES (DEPTH)
    ) sync_i (
        .clk      (clk),
        .rst      (rst),
        .async_in (pin_level),
        .sync_out (sync_lvl)
    );

    pes_warmup #(
        .HOLD (WARM)
    ) warm_i (
        .clk   (clk),
        .rst   (rst),
        .ready (warm_ready)
    );

    assign fire_ok = bank_en & warm_ready;

    pes_edge_detect #(
        .WIDTH (PIN_COUNT)
    ) det_i (
        .clk      (clk),
        .rst      (rst),
        .sync_lvl (sync_lvl),
        .rise_en  (rise_en),
        .fall_en  (fall_en),
        .fire_ok  (fire_ok),
        .hist_lvl (hist_lvl),
        .evt      (evt_pulse)
    );

endmodule

// File: rtl/pes_checker.sv
module pes_checker #(
    parameter int PIN_COUNT = 16
) (
    input logic                 clk,
    input logic                 rst,
    input logic [PIN_COUNT-1:0] rise_en,
    input logic [PIN_COUNT-1:0] fall_en,
    input logic                 bank_en,
    input logic [PIN_COUNT-1:0] sync_lvl,
    input logic [PIN_COUNT-1:0] hist_lvl,
    input logic [PIN_COUNT-1:0] evt_pulse
);

    assert_quiet_after_reset_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> evt_pulse == '0);

    assert_rise_only_R2: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse & $past(rise_en & ~fall_en & ~sync_lvl)) == '0);

    assert_fall_only_R3: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse & $past(fall_en & ~rise_en & sync_lvl)) == '0);

    assert_disabled_pin_R5: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse & $past(~rise_en & ~fall_en)) == '0);

    assert_pulse_needs_edge_R6: assert property (@(posedge clk) disable iff (rst)
        (evt_pulse & ~$past(sync_lvl ^ hist_lvl)) == '0);

    assert_bank_gate_R7: assert property (@(posedge clk) disable iff (rst)
        !bank_en |=> evt_pulse == '0);

endmodule

bind pin_edge_event pes_checker #(.PIN_COUNT(PIN_COUNT)) chk_i (
    .clk       (clk),
    .rst       (rst),
    .rise_en   (rise_en),
    .fall_en   (fall_en),
    .bank_en   (bank_en),
    .sync_lvl  (sync_lvl),
    .hist_lvl  (hist_lvl),
    .evt_pulse (evt_pulse)
);

// File: tb/pin_edge_event_tb_top.sv
module pin_edge_event_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int N          = 16;
    localparam int STAGES     = 2;
    localparam int WARM       = STAGES + 1;
    localparam int WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [N-1:0] pin  = '0;
    logic [N-1:0] rise = '0;
    logic [N-1:0] fall = '0;
    logic         bank = 1'b0;
    logic [N-1:0] evt;

    int    checks = 0;
    int    errors = 0;
    int    rel_cnt = 0;
    string req = "R1";
    string exp_req = "R1";
    logic [N-1:0] exp_evt = '0;
    logic [N-1:0] ph [0:STAGES+1];
    bit    done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    pin_edge_event #(.PIN_COUNT(N), .SYNC_STAGES(STAGES)) dut_i (
        .clk       (clk),
        .rst       (rst),
        .pin_level (pin),
        .rise_en   (rise),
        .fall_en   (fall),
        .bank_en   (bank),
        .evt_pulse (evt)
    );

    // Expected pulse from the mode table and the bank gate.
    function automatic logic [N-1:0] model_evt(input logic b, input logic [N-1:0] r,
            input logic [N-1:0] f, input logic [N-1:0] cur, input logic [N-1:0] prev);
        logic [N-1:0] res;
        res = '0;
        for (int i = 0; i < N; i++) begin
            case ({r[i], f[i]})
                2'b10:   res[i] = cur[i] & !prev[i];
                2'b01:   res[i] = !cur[i] & prev[i];
                2'b11:   res[i] = cur[i] != prev[i];
                default: res[i] = 1'b0;
            endcase
        end
        return b ? res : '0;
    endfunction

    // One clock: check the last prediction, drive new inputs, predict the next edge.
    task automatic step(input logic [N-1:0] p, input logic [N-1:0] r,
                        input logic [N-1:0] f, input logic b, input logic rs);
        @(negedge clk);
        checks++;
        if (evt !== exp_evt) begin
            errors++;
            $display("FAIL %s actual %h expected %h at %0t", exp_req, evt, exp_evt, $time);
        end
        pin = p; rise = r; fall = f; bank = b; rst = rs;
        for (int k = STAGES + 1; k > 0; k--) ph[k] = ph[k-1];
        ph[0] = rs ? '0 : p;
        if (rs) rel_cnt = 0; else rel_cnt++;
        exp_evt = (rs || rel_cnt <= WARM) ? '0 : model_evt(b, r, f, ph[STAGES], ph[STAGES+1]);
        exp_req = req;
    endtask

    initial begin
        for (int k = 0; k <= STAGES + 1; k++) ph[k] = '0;
    end

    initial begin
        logic [N-1:0] rp, rr, rf, lv;
        int pulses;
        void'($urandom(32'h5eed_0042));

        // R1: pins high and all edges enabled through reset and warm-up.
        req = "R1";
        for (int c = 0; c < 4; c++) step('1, '1, '1, 1'b1, 1'b1);
        for (int c = 0; c < 6; c++) step('1, '1, '1, 1'b1, 1'b0);

        // R2: rising-only on every pin, random levels.
        req = "R2";
        for (int c = 0; c < 300; c++) step(N'($urandom), '1, '0, 1'b1, 1'b0);

        // R3: falling-only.
        req = "R3";
        for (int c = 0; c < 300; c++) step(N'($urandom), '0, '1, 1'b1, 1'b0);

        // R4: both edges.
        req = "R4";
        for (int c = 0; c < 300; c++) step(N'($urandom), '1, '1, 1'b1, 1'b0);

        // R5: both enables off.
        req = "R5";
        for (int c = 0; c < 200; c++) step(N'($urandom), '0, '0, 1'b1, 1'b0);

        // R8: mixed modes per pin with random levels.
        req = "R8";
        for (int c = 0; c < 600; c++) begin
            if (c % 50 == 0) begin rr = N'($urandom); rf = N'($urandom); end
            step(N'($urandom), rr, rf, 1'b1, 1'b0);
        end

        // R6: isolated step on pin 3; pulse after three edges, one cycle wide.
        req = "R6";
        for (int c = 0; c < 6; c++) step('0, 16'h0008, '0, 1'b1, 1'b0);
        step(16'h0008, 16'h0008, '0, 1'b1, 1'b0);
        pulses = 0;
        for (int c = 0; c < 6; c++) begin
            step(16'h0008, 16'h0008, '0, 1'b1, 1'b0);
            if (evt[3]) begin
                pulses++;
                checks++;
                if (c != 2) begin
                    errors++;
                    $display("FAIL R6 pulse latency actual %0d expected 2", c);
                end
            end
        end
        checks++;
        if (pulses != 1) begin
            errors++;
            $display("FAIL R6 pulse width actual %0d expected 1", pulses);
        end

        // R7: bank disabled while pins toggle; edges dropped, not pending.
        req = "R7";
        for (int c = 0; c < 200; c++) step(N'($urandom), '1, '1, 1'b0, 1'b0);
        lv = N'($urandom);
        for (int c = 0; c < 6; c++) step(lv, '1, '1, 1'b0, 1'b0);
        for (int c = 0; c < 10; c++) step(lv, '1, '1, 1'b1, 1'b0);
        for (int c = 0; c < 100; c++) step(N'($urandom), '1, '1, N'($urandom) % 2 == 1, 1'b0);

        // R9: steady pins, enables change every cycle.
        req = "R9";
        lv = N'($urandom);
        for (int c = 0; c < 6; c++) step(lv, '0, '0, 1'b1, 1'b0);
        for (int c = 0; c < 200; c++) step(lv, N'($urandom), N'($urandom), 1'b1, 1'b0);
        // New enable applies immediately to the next edge.
        step(lv, '0, '0, 1'b1, 1'b0);
        step(~lv, '0, '0, 1'b1, 1'b0);
        step(~lv, '0, '0, 1'b1, 1'b0);
        step(~lv, '1, '1, 1'b1, 1'b0);
        for (int c = 0; c < 4; c++) step(~lv, '1, '1, 1'b1, 1'b0);

        // R10: every-cycle toggling in both-edge mode.
        req = "R10";
        rp = 16'hA5A5;
        for (int c = 0; c < 100; c++) begin
            rp = ~rp;
            step(rp, '1, '1, 1'b1, 1'b0);
        end

        // R1: mid-run reset with random pins held.
        req = "R1";
        for (int c = 0; c < 3; c++) step(N'($urandom), '1, '1, 1'b1, 1'b1);
        for (int c = 0; c < 100; c++) step(N'($urandom), '1, '1, 1'b1, 1'b0);

        step('0, '0, '0, 1'b1, 1'b0);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int c = 0; c < WATCHDOG; c++) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule